// File: doc/BRIEF.md
# Instruction Decode Control Unit

This block turns one 32-bit integer base-ISA instruction word into the full set of datapath controls for a single-cycle core. It is purely combinational: the instruction word goes in, and the same cycle produces the register addresses, the sign-extended immediate, the ALU operation with its modifiers, the operand and write-back source selects, the program-counter source and the write enables. It handles the register-immediate and register-register ALU classes, loads, stores, conditional branches, the two jump forms and the two upper-immediate forms. Any other opcode decodes to a harmless no-operation.

Conditional branches have no comparator of their own. The decoder sets the ALU to a subtract or to a less-than compare. It raises a branch-enable and, where needed, an invert-zero control, so the core takes the branch when `branch_o & (alu_zero ^ br_neg_zero_o)` is true.

Top module: `ctl_decode_top`

## Requirements
- R1: `reg_we_o` is 1 for opcodes 0010011, 0110011, 0000011, 1101111, 1100111, 0010111 and 0110111. It is 0 for store (0100011), branch (1100011) and every other opcode.
- R2: `mem_we_o` is 1 only for opcode 0100011.
- R3: For opcodes 0010011, 0000011 and 1100111, `imm_o` is instruction bits [31:20] sign-extended from bit 31.
- R4: For a store, `imm_o` is {bits[31:25], bits[11:7]} sign-extended from bit 31.
- R5: For a branch, `imm_o` is a 13-bit offset, sign-extended, with bit 12 from instr[31], bit 11 from instr[7], bits 10:5 from instr[30:25], bits 4:1 from instr[11:8], and bit 0 equal to 0.
- R6: For jal (1101111), `imm_o` is a 21-bit offset, sign-extended, with bit 20 from instr[31], bits 19:12 from instr[19:12], bit 11 from instr[20], bits 10:1 from instr[30:21], and bit 0 equal to 0.
- R7: For auipc (0010111) and lui (0110111), `imm_o` is instr[31:12] followed by twelve zero bits. Every other opcode gives `imm_o` = 0.
- R8: For the two ALU classes, `alu_op_o` equals funct3 (000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 shift right, 110 or, 111 and). `alu_signed_o` is set when funct3 = 101 and instr[30] = 1. On opcode 0110011 only, funct3 = 000 with instr[30] = 1 sets both `alu_neg_o` and `alu_inc_o` (subtract); with instr[30] = 0 it stays an add. Loads, stores, jumps and upper-immediate forms use add with no modifiers.
- R9: For beq (funct3 000) and bne (001), the ALU does add with `alu_neg_o` = `alu_inc_o` = 1 and `branch_o` = 1. `br_neg_zero_o` is 0 for beq and 1 for bne.
- R10: For blt (100) and bge (101), `alu_op_o` = 010. For bltu (110) and bgeu (111), `alu_op_o` = 011. `branch_o` is 1 for all four, and `br_neg_zero_o` is 1 for blt and bltu only. A branch with funct3 010 or 011 gives `branch_o` = 0, `pc_sel_o` = 0 and a plain add.
- R11: `pc_sel_o` is 1 (PC plus immediate) for jal and for valid branches, 2 (rs1 plus immediate) for jalr, and 0 (sequential) otherwise. `jump_o` is 1 only for jal and jalr.
- R12: `wb_sel_o` is 1 (memory data) for loads, 2 (PC plus 4) for jal and jalr, and 0 (ALU result) otherwise.
- R13: `opa_sel_o` is 1 (PC) for jal and auipc, 2 (zero) for lui, and 0 (rs1) otherwise. `opb_sel_o` is 1 (immediate) for op-imm, load, store, jal, jalr, auipc and lui, and 0 (rs2) otherwise.
- R14: `rs1_o`, `rs2_o` and `rd_o` always equal instr[19:15], instr[24:20] and instr[11:7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| mem_we_o | output | 1 | Data memory write enable |
| pc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 PC+imm, 2 rs1+imm |
| jump_o | output | 1 | Unconditional jump |
| branch_o | output | 1 | Conditional branch, resolved on ALU zero |
| br_neg_zero_o | output | 1 | Take branch when ALU result is nonzero |
| imm_o | output | XLEN | Sign-extended immediate |
| opa_sel_o | output | 2 | ALU operand A: 0 rs1, 1 PC, 2 zero |
| opb_sel_o | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| alu_op_o | output | 3 | ALU operation code |
| alu_signed_o | output | 1 | Arithmetic form of shift right |
| alu_neg_o | output | 1 | Invert operand B |
| alu_inc_o | output | 1 | Carry-in of one |
| rs1_o | output | REG_AW | Source register 1 address |
| rs2_o | output | REG_AW | Source register 2 address |
| rd_o | output | REG_AW | Destination register address |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| reg_we_o | output | 1 | Register file write enable |

## Verification
The bench builds the block with its defaults: XLEN = 32 and REG_AW = 5. At this width every immediate format fills the whole output, so the sign-extension boundary of each format is visible at the port, and the five address bits reach all 32 registers. Random words over every class, including the reserved branch funct3 values and an unknown opcode, cover the full funct3/bit-30 space. Directed words place the most negative offset of each format on the output.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int ILEN = 32;

    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;

    typedef enum logic [3:0] {
        CL_NONE, CL_OPIMM, CL_OP, CL_LOAD, CL_STORE,
        CL_BRANCH, CL_JAL, CL_JALR, CL_AUIPC, CL_LUI
    } instr_class_e;

    typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_REL = 2'd1, PC_REG = 2'd2} pc_sel_e;
    typedef enum logic [1:0] {OPA_RS1 = 2'd0, OPA_PC = 2'd1, OPA_ZERO = 2'd2} opa_sel_e;
    typedef enum logic       {OPB_RS2 = 1'b0, OPB_IMM = 1'b1} opb_sel_e;
    typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_sel_e;
    typedef enum logic [2:0] {IMM_NONE, IMM_I, IMM_S, IMM_B, IMM_J, IMM_U} imm_fmt_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0, ALU_SLL = 3'd1, ALU_SLT = 3'd2, ALU_SLTU = 3'd3,
        ALU_XOR = 3'd4, ALU_SR  = 3'd5, ALU_OR  = 3'd6, ALU_AND  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic     reg_we;
        logic     mem_we;
        logic     jump;
        pc_sel_e  pc_sel;
        opa_sel_e opa_sel;
        opb_sel_e opb_sel;
        wb_sel_e  wb_sel;
        imm_fmt_e imm_fmt;
    } class_ctl_t;

    typedef struct packed {
        alu_op_e op;
        logic    sgn;
        logic    neg;
        logic    inc;
        logic    branch;
        logic    br_neg_zero;
    } alu_ctl_t;

    function automatic instr_class_e classify(input logic [6:0] opc);
        case (opc)
            OPC_OPIMM:  return CL_OPIMM;
            OPC_OP:     return CL_OP;
            OPC_LOAD:   return CL_LOAD;
            OPC_STORE:  return CL_STORE;
            OPC_BRANCH: return CL_BRANCH;
            OPC_JAL:    return CL_JAL;
            OPC_JALR:   return CL_JALR;
            OPC_AUIPC:  return CL_AUIPC;
            OPC_LUI:    return CL_LUI;
            default:    return CL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctl_class_dec.sv
module ctl_class_dec
    import ctl_pkg::*;
(
    input  logic [6:0]   opcode_i,
    output instr_class_e cls_o,
    output class_ctl_t   ctl_o
);

    always_comb begin
        cls_o = classify(opcode_i);
        ctl_o = '{reg_we: 1'b0, mem_we: 1'b0, jump: 1'b0, pc_sel: PC_SEQ,
                  opa_sel: OPA_RS1, opb_sel: OPB_RS2, wb_sel: WB_ALU,
                  imm_fmt: IMM_NONE};
        case (cls_o)
            CL_OPIMM: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.imm_fmt = IMM_I;
            end
            CL_OP: ctl_o.reg_we = 1'b1;
            CL_LOAD: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.wb_sel  = WB_MEM;
                ctl_o.imm_fmt = IMM_I;
            end
            CL_STORE: begin
                ctl_o.mem_we  = 1'b1;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.imm_fmt = IMM_S;
            end
            CL_BRANCH: begin
                ctl_o.pc_sel  = PC_REL;
                ctl_o.imm_fmt = IMM_B;
            end
            CL_JAL: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.jump    = 1'b1;
                ctl_o.pc_sel  = PC_REL;
                ctl_o.opa_sel = OPA_PC;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.wb_sel  = WB_LINK;
                ctl_o.imm_fmt = IMM_J;
            end
            CL_JALR: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.jump    = 1'b1;
                ctl_o.pc_sel  = PC_REG;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.wb_sel  = WB_LINK;
                ctl_o.imm_fmt = IMM_I;
            end
            CL_AUIPC: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.opa_sel = OPA_PC;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.imm_fmt = IMM_U;
            end
            CL_LUI: begin
                ctl_o.reg_we  = 1'b1;
                ctl_o.opa_sel = OPA_ZERO;
                ctl_o.opb_sel = OPB_IMM;
                ctl_o.imm_fmt = IMM_U;
            end
            default: ;
        endcase
    end

    // R1: a store never writes the register file, a branch writes nothing
    always_comb begin
        if (cls_o == CL_STORE || cls_o == CL_BRANCH)
            a_r1_no_reg_write: assert (!ctl_o.reg_we)
                else $error("reg write on store/branch");
    end

endmodule

// File: rtl/ctl_imm_gen.sv
module ctl_imm_gen
    import ctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:7] ibits_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);

    logic signed [ILEN-1:0] raw;
    logic signed [XLEN-1:0] ext;

    always_comb begin
        raw = '0;
        case (fmt_i)
            IMM_I: raw = {{20{ibits_i[31]}}, ibits_i[31:20]};
            IMM_S: raw = {{20{ibits_i[31]}}, ibits_i[31:25], ibits_i[11:7]};
            IMM_B: raw = {{19{ibits_i[31]}}, ibits_i[31], ibits_i[7],
                          ibits_i[30:25], ibits_i[11:8], 1'b0};
            IMM_J: raw = {{11{ibits_i[31]}}, ibits_i[31], ibits_i[19:12],
                          ibits_i[20], ibits_i[30:21], 1'b0};
            IMM_U: raw = {ibits_i[31:12], 12'h000};
            default: raw = '0;
        endcase
        ext   = raw;
        imm_o = ext;
    end

    // R7: upper-immediate forms leave the low twelve bits clear
    // R3: every real format carries the instruction sign bit to the top
    always_comb begin
        if (fmt_i == IMM_U)
            a_r7_upper_low_clear: assert (imm_o[11:0] == 12'h000)
                else $error("upper imm low bits set");
        if (fmt_i != IMM_NONE)
            a_r3_sign_top: assert (imm_o[XLEN-1] == ibits_i[31])
                else $error("imm sign lost");
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  instr_class_e cls_i,
    input  logic [2:0]   funct3_i,
    input  logic         alt_i,
    output alu_ctl_t     alu_o
);

    always_comb begin
        alu_o = '{op: ALU_ADD, sgn: 1'b0, neg: 1'b0, inc: 1'b0,
                  branch: 1'b0, br_neg_zero: 1'b0};
        case (cls_i)
            CL_OPIMM, CL_OP: begin
                alu_o.op  = alu_op_e'(funct3_i);
                alu_o.sgn = (funct3_i == 3'b101) && alt_i;
                if (cls_i == CL_OP && funct3_i == 3'b000 && alt_i) begin
                    alu_o.neg = 1'b1;
                    alu_o.inc = 1'b1;
                end
            end
            CL_BRANCH: begin
                case (funct3_i)
                    3'b000, 3'b001: begin
                        alu_o.neg         = 1'b1;
                        alu_o.inc         = 1'b1;
                        alu_o.branch      = 1'b1;
                        alu_o.br_neg_zero = funct3_i[0];
                    end
                    3'b100, 3'b101: begin
                        alu_o.op          = ALU_SLT;
                        alu_o.branch      = 1'b1;
                        alu_o.br_neg_zero = ~funct3_i[0];
                    end
                    3'b110, 3'b111: begin
                        alu_o.op          = ALU_SLTU;
                        alu_o.branch      = 1'b1;
                        alu_o.br_neg_zero = ~funct3_i[0];
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // R9: invert and carry-in travel together (two's complement subtract)
    // R10: the invert-zero control is meaningful only on a branch
    always_comb begin
        a_r9_sub_pair: assert (alu_o.neg == alu_o.inc)
            else $error("negate without add-one");
        if (alu_o.br_neg_zero)
            a_r10_negz_needs_branch: assert (alu_o.branch && cls_i == CL_BRANCH)
                else $error("negate-zero outside branch");
    end

endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
    import ctl_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [ILEN-1:0]   instr_i,
    output logic              mem_we_o,
    output logic [1:0]        pc_sel_o,
    output logic              jump_o,
    output logic              branch_o,
    output logic              br_neg_zero_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [1:0]        opa_sel_o,
    output logic              opb_sel_o,
    output logic [2:0]        alu_op_o,
    output logic              alu_signed_o,
    output logic              alu_neg_o,
    output logic              alu_inc_o,
    output logic [REG_AW-1:0] rs1_o,
    output logic [REG_AW-1:0] rs2_o,
    output logic [REG_AW-1:0] rd_o,
    output logic [1:0]        wb_sel_o,
    output logic              reg_we_o
);

    localparam int RS1_LSB = 15;
    localparam int RS2_LSB = 20;
    localparam int RD_LSB  = 7;

    instr_class_e cls;
    class_ctl_t   ctl;
    alu_ctl_t     alu;
    pc_sel_e      pc_sel;

    ctl_class_dec u_class (
        .opcode_i (instr_i[6:0]),
        .cls_o    (cls),
        .ctl_o    (ctl)
    );

    ctl_imm_gen #(.XLEN(XLEN)) u_imm (
        .ibits_i (instr_i[ILEN-1:7]),
        .fmt_i   (ctl.imm_fmt),
        .imm_o   (imm_o)
    );

    ctl_alu_dec u_alu (
        .cls_i    (cls),
        .funct3_i (instr_i[14:12]),
        .alt_i    (instr_i[30]),
        .alu_o    (alu)
    );

    always_comb begin
        pc_sel = ctl.pc_sel;
        if (cls == CL_BRANCH && !alu.branch)
            pc_sel = PC_SEQ;
    end

    assign mem_we_o      = ctl.mem_we;
    assign reg_we_o      = ctl.reg_we;
    assign jump_o        = ctl.jump;
    assign pc_sel_o      = pc_sel;
    assign opa_sel_o     = ctl.opa_sel;
    assign opb_sel_o     = ctl.opb_sel;
    assign wb_sel_o      = ctl.wb_sel;
    assign branch_o      = alu.branch;
    assign br_neg_zero_o = alu.br_neg_zero;
    assign alu_op_o      = alu.op;
    assign alu_signed_o  = alu.sgn;
    assign alu_neg_o     = alu.neg;
    assign alu_inc_o     = alu.inc;
    assign rs1_o         = instr_i[RS1_LSB +: REG_AW];
    assign rs2_o         = instr_i[RS2_LSB +: REG_AW];
    assign rd_o          = instr_i[RD_LSB  +: REG_AW];

    // R2: memory is written only by the store opcode
    // R11: a jump or taken-capable branch always names a non-sequential target
    always_comb begin
        if (mem_we_o)
            a_r2_store_only: assert (instr_i[6:0] == OPC_STORE)
                else $error("mem write on non-store");
        if (jump_o || branch_o)
            a_r11_target_set: assert (pc_sel_o != 2'd0)
                else $error("jump without target");
        if (jump_o)
            a_r12_link_data: assert (wb_sel_o == 2'd2 && reg_we_o)
                else $error("jump without link");
    end

endmodule

// File: tb/ctl_decode_top_tb_top.sv
module ctl_decode_top_tb_top;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NRAND  = 800;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [31:0]       instr;
    logic              mem_we, jump, branch, bnz, opb, sgn, neg, inc, reg_we;
    logic [1:0]        pc_sel, opa, wb;
    logic [XLEN-1:0]   imm;
    logic [2:0]        alu_op;
    logic [REG_AW-1:0] rs1, rs2, rd;

    ctl_decode_top #(.XLEN(XLEN), .REG_AW(REG_AW)) dut_i (
        .instr_i(instr), .mem_we_o(mem_we), .pc_sel_o(pc_sel), .jump_o(jump),
        .branch_o(branch), .br_neg_zero_o(bnz), .imm_o(imm), .opa_sel_o(opa),
        .opb_sel_o(opb), .alu_op_o(alu_op), .alu_signed_o(sgn), .alu_neg_o(neg),
        .alu_inc_o(inc), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .wb_sel_o(wb),
        .reg_we_o(reg_we)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic [31:0] imm;
        logic [1:0]  pc_sel;
        logic        jump, branch, bnz, mem_we, reg_we;
        logic [1:0]  opa;
        logic        opb;
        logic [2:0]  alu_op;
        logic        sgn, neg, inc;
        logic [1:0]  wb;
    } exp_t;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s instr=%h actual=%h expected=%h",
                     tag, what, instr, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input int top);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[k] = (k <= top) ? v[k] : v[top];
        return r;
    endfunction

    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [31:0] t;
        logic [2:0] f3;
        e  = '0;
        t  = '0;
        f3 = w[14:12];
        case (w[6:0])
            7'b0010011: begin
                e.reg_we = 1; e.opb = 1; e.imm = sx({20'h0, w[31:20]}, 11);
                e.alu_op = f3; e.sgn = (f3 == 3'd5) && w[30];
            end
            7'b0110011: begin
                e.reg_we = 1; e.alu_op = f3; e.sgn = (f3 == 3'd5) && w[30];
                e.neg = (f3 == 3'd0) && w[30]; e.inc = e.neg;
            end
            7'b0000011: begin
                e.reg_we = 1; e.opb = 1; e.wb = 2'd1;
                e.imm = sx({20'h0, w[31:20]}, 11);
            end
            7'b0100011: begin
                e.mem_we = 1; e.opb = 1;
                t[11:5] = w[31:25]; t[4:0] = w[11:7];
                e.imm = sx(t, 11);
            end
            7'b1100011: begin
                t[12] = w[31]; t[11] = w[7]; t[10:5] = w[30:25]; t[4:1] = w[11:8];
                e.imm = sx(t, 12);
                case (f3)
                    3'd0: begin e.branch = 1; e.neg = 1; e.inc = 1; end
                    3'd1: begin e.branch = 1; e.neg = 1; e.inc = 1; e.bnz = 1; end
                    3'd4: begin e.branch = 1; e.alu_op = 3'd2; e.bnz = 1; end
                    3'd5: begin e.branch = 1; e.alu_op = 3'd2; end
                    3'd6: begin e.branch = 1; e.alu_op = 3'd3; e.bnz = 1; end
                    3'd7: begin e.branch = 1; e.alu_op = 3'd3; end
                    default: ;
                endcase
                e.pc_sel = e.branch ? 2'd1 : 2'd0;
            end
            7'b1101111: begin
                t[20] = w[31]; t[19:12] = w[19:12]; t[11] = w[20]; t[10:1] = w[30:21];
                e.imm = sx(t, 20);
                e.reg_we = 1; e.jump = 1; e.pc_sel = 2'd1; e.opa = 2'd1;
                e.opb = 1; e.wb = 2'd2;
            end
            7'b1100111: begin
                e.imm = sx({20'h0, w[31:20]}, 11);
                e.reg_we = 1; e.jump = 1; e.pc_sel = 2'd2; e.opb = 1; e.wb = 2'd2;
            end
            7'b0010111: begin
                e.imm = w & 32'hFFFF_F000; e.reg_we = 1; e.opa = 2'd1; e.opb = 1;
            end
            7'b0110111: begin
                e.imm = w & 32'hFFFF_F000; e.reg_we = 1; e.opa = 2'd2; e.opb = 1;
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string imm_tag(input logic [6:0] o);
        case (o)
            7'b0100011: return "R4";
            7'b1100011: return "R5";
            7'b1101111: return "R6";
            7'b0010111, 7'b0110111: return "R7";
            7'b0010011, 7'b0000011, 7'b1100111: return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_and_check(input logic [31:0] w);
        exp_t e;
        string at;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        e  = model(w);
        at = (w[6:0] == 7'b1100011) ? ((w[14:13] == 2'b00) ? "R9" : "R10") : "R8";
        chk("R1",  "reg_we",  {31'h0, reg_we}, {31'h0, e.reg_we});
        chk("R2",  "mem_we",  {31'h0, mem_we}, {31'h0, e.mem_we});
        chk(imm_tag(w[6:0]), "imm", imm, e.imm);
        chk(at,    "alu_op",  {29'h0, alu_op}, {29'h0, e.alu_op});
        chk(at,    "signed",  {31'h0, sgn}, {31'h0, e.sgn});
        chk(at,    "negate",  {31'h0, neg}, {31'h0, e.neg});
        chk(at,    "add_one", {31'h0, inc}, {31'h0, e.inc});
        chk(at,    "branch",  {31'h0, branch}, {31'h0, e.branch});
        chk(at,    "neg_zero",{31'h0, bnz}, {31'h0, e.bnz});
        chk("R11", "pc_sel",  {30'h0, pc_sel}, {30'h0, e.pc_sel});
        chk("R11", "jump",    {31'h0, jump}, {31'h0, e.jump});
        chk("R12", "wb_sel",  {30'h0, wb}, {30'h0, e.wb});
        chk("R13", "opa_sel", {30'h0, opa}, {30'h0, e.opa});
        chk("R13", "opb_sel", {31'h0, opb}, {31'h0, e.opb});
        chk("R14", "rs1",     {27'h0, rs1}, {27'h0, w[19:15]});
        chk("R14", "rs2",     {27'h0, rs2}, {27'h0, w[24:20]});
        chk("R14", "rd",      {27'h0, rd},  {27'h0, w[11:7]});
    endtask

    function automatic logic [6:0] pick_opc(input int unsigned n);
        case (n % 10)
            0: return 7'b0010011;
            1: return 7'b0110011;
            2: return 7'b0000011;
            3: return 7'b0100011;
            4: return 7'b1100011;
            5: return 7'b1101111;
            6: return 7'b1100111;
            7: return 7'b0010111;
            8: return 7'b0110111;
            default: return 7'b1110011;
        endcase
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        instr = 32'h0000_0013;
        @(negedge clk);
        // R1 R2: nop-equivalent start state (addi x0,x0,0)
        chk("R1", "reg_we start", {31'h0, reg_we}, 32'h1);
        chk("R2", "mem_we start", {31'h0, mem_we}, 32'h0);

        // R8: sub versus add on the register-register class
        apply_and_check({7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011});
        chk("R8", "sub negate", {31'h0, neg}, 32'h1);
        apply_and_check({7'b0000000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011});
        chk("R8", "add negate", {31'h0, neg}, 32'h0);
        // R8: sub encoding on op-imm stays an add
        apply_and_check({7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0010011});
        chk("R8", "addi no negate", {31'h0, neg}, 32'h0);
        // R3: most negative I immediate
        apply_and_check({12'h800, 5'd2, 3'b010, 5'd1, 7'b0000011});
        chk("R3", "load imm min", imm, 32'hFFFF_F800);
        // R4: store immediate all ones
        apply_and_check({7'h7F, 5'd1, 5'd2, 3'b010, 5'h1F, 7'b0100011});
        chk("R4", "store imm -1", imm, 32'hFFFF_FFFF);
        // R5: branch offset all ones gives -2
        apply_and_check({7'h7F, 5'd1, 5'd2, 3'b001, 5'h1F, 7'b1100011});
        chk("R5", "branch imm -2", imm, 32'hFFFF_FFFE);
        chk("R9", "bne neg_zero", {31'h0, bnz}, 32'h1);
        // R6: jal offset all ones gives -2
        apply_and_check({20'hFFFFF, 5'd1, 7'b1101111});
        chk("R6", "jal imm -2", imm, 32'hFFFF_FFFE);
        // R7: lui upper immediate
        apply_and_check({20'hA000A, 5'd1, 7'b0110111});
        chk("R7", "lui imm", imm, 32'hA000_A000);
        // R10: each compare branch and the reserved funct3 values
        for (int f = 0; f < 8; f++)
            apply_and_check({7'h00, 5'd4, 5'd5, 3'(f), 5'd6, 7'b1100011});
        apply_and_check({17'h0, 3'b110, 5'd0, 7'b1100011});
        chk("R10", "bltu op", {29'h0, alu_op}, 32'd3);
        // R1: unknown opcode writes nothing
        apply_and_check(32'h0000_0073);
        chk("R1", "unknown no write", {31'h0, reg_we}, 32'h0);

        for (int i = 0; i < NRAND; i++)
            apply_and_check({$urandom() & 32'hFFFF_FF80} | {25'h0, pick_opc($urandom())});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule